// File: doc/BRIEF.md
# Dual-Buffer Transmit Frame Controller

This block is the transmit half of a small memory-mapped Ethernet MAC. It holds two frame buffers, and each one has its own length, interrupt-enable and control register. Software fills a buffer with 32-bit word writes, sets the byte count, and then writes the control register with the start bit set. The program bit in that same write picks the job. With the program bit clear, the block streams the frame out of a byte-wide valid/ready/last interface. With the program bit set, it instead copies the first six buffer bytes into the station address output.

One sequencer serves both buffers. Software can therefore fill one buffer while the other is draining, which gives ping-pong operation. When a job finishes, the start and program bits clear themselves. A one-cycle interrupt pulse follows if the buffer's own enable bit is set and the master enable in buffer 0's register is on. Preamble, FCS, PHY signalling and management access lie outside this block.

Top module: `txfb_ctrl`

## Requirements
- R1: After reset, every length, enable and control register reads 0, `tx_valid` and `irq` are low and `mac_addr` is 0.
- R2: Address bit 11 selects the buffer. Inside a buffer, byte offsets 0x000 to 0x7E3 are frame data. The registers sit at fixed offsets: length at 0x7F4, interrupt enable at 0x7F8, control at 0x7FC. Accesses are whole 32-bit words. Read data appears on `bus_rdata` one cycle after the `bus_rd` strobe. Unmapped offsets read 0.
- R3: A control write with bit 0 (start) = 1 and bit 1 (program) = 0 sends the number of bytes held in that buffer's length register. Bytes leave in increasing address order. Inside each word the least significant byte goes first. `tx_last` is high on the final byte only.
- R4: When a job completes, `irq` pulses high for exactly one cycle, and only when two conditions hold: control bit 3 of that buffer is set, and bit 31 of buffer 0's enable register is set. Buffer 1's enable register has no effect on `irq`.
- R5: A control write with start = 1 and program = 1 sends no bytes. It loads `mac_addr` with byte 0 in bits 47:40, byte 1 in bits 39:32, and so on down to byte 5 in bits 7:0.
- R6: The start and program bits read back as 1 while the job runs and read 0 once it completes. All other control bits keep the value that was written.
- R7: While a buffer's start bit is 1, control writes to that buffer are ignored, including a second start.
- R8: A send with length 0 completes with no byte transferred.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold steady.
- R10: A control write with start = 0 starts nothing, and the start and program bits read back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | 12 | Byte address; bit 11 picks the buffer |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | Byte on `tx_data` is valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| mac_addr | output | 48 | Station address, first octet in the top byte |
| irq | output | 1 | One-cycle completion pulse |

## Verification
A scoreboard predicts every byte and its last flag from what was written into the buffers. Any error in lane order, word stepping or last placement shows up as a byte mismatch. The bench holds `tx_ready` low and then toggles it. A stream that advances without a handshake would drop or repeat scoreboard entries. A second start written during a stalled send must neither restart the frame nor overwrite the stored enable bit; getting this wrong would produce extra bytes or a missing pulse. The bench also covers the enable gating from buffer 0 only, zero length, address loading with byte order checked, and control writes with no start bit. A design that mishandled any of these would show a wrong `irq` count, stray bytes or a wrong `mac_addr`.

// File: rtl/txfb_pkg.sv
package txfb_pkg;
   localparam int BUS_W      = 32;
   localparam int CTRL_START = 0;
   localparam int CTRL_PROG  = 1;
   localparam int CTRL_IEN   = 3;
   localparam int GIE_BIT    = 31;

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_SEND,
      ENG_MAC_LO,
      ENG_MAC_HI
   } eng_state_e;
endpackage

// File: rtl/txfb_bufmem.sv
module txfb_bufmem #(
   parameter int NUM_BUF = 2,
   parameter int WORDS   = 505,
   localparam int WIDX_W = $clog2(WORDS),
   localparam int BSEL_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [BSEL_W-1:0] wbuf,
   input  logic [WIDX_W-1:0] widx,
   input  logic [31:0]       wdata,
   input  logic [BSEL_W-1:0] rbuf_a,
   input  logic [WIDX_W-1:0] ridx_a,
   output logic [31:0]       rdata_a,
   input  logic [BSEL_W-1:0] rbuf_b,
   input  logic [WIDX_W-1:0] ridx_b,
   output logic [31:0]       rdata_b
);
   logic [31:0] rd_a [NUM_BUF];
   logic [31:0] rd_b [NUM_BUF];

   for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
      logic [31:0] arr [WORDS];
      always_ff @(posedge clk) begin
         if (we && (wbuf == BSEL_W'(b))) arr[widx] <= wdata;
      end
      assign rd_a[b] = arr[ridx_a];
      assign rd_b[b] = arr[ridx_b];
   end

   assign rdata_a = rd_a[rbuf_a];
   assign rdata_b = rd_b[rbuf_b];
endmodule

// File: rtl/txfb_bufregs.sv
module txfb_bufregs
   import txfb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             len_we,
   input  logic             gie_we,
   input  logic             ctrl_we,
   input  logic [BUS_W-1:0] wdata,
   input  logic             done,
   output logic [BUS_W-1:0] len_q,
   output logic [BUS_W-1:0] gie_q,
   output logic [BUS_W-1:0] ctrl_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q  <= '0;
         gie_q  <= '0;
         ctrl_q <= '0;
      end else begin
         if (len_we) len_q <= wdata;
         if (gie_we) gie_q <= wdata;
         if (ctrl_we && !ctrl_q[CTRL_START]) begin
            ctrl_q <= wdata;
            // without a start request nothing runs, so the job bits stay 0 (R10)
            if (!wdata[CTRL_START]) ctrl_q[CTRL_PROG] <= 1'b0;
         end else if (done) begin
            ctrl_q[CTRL_START] <= 1'b0;
            ctrl_q[CTRL_PROG]  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/txfb_engine.sv
module txfb_engine
   import txfb_pkg::*;
#(
   parameter int NUM_BUF   = 2,
   parameter int BUF_BYTES = 2020,
   localparam int WORDS    = BUF_BYTES / 4,
   localparam int WIDX_W   = $clog2(WORDS),
   localparam int LEN_W    = $clog2(BUF_BYTES + 1),
   localparam int BSEL_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_BUF-1:0] start_pend,
   input  logic [NUM_BUF-1:0] prog_pend,
   input  logic [BUS_W-1:0]  len_in [NUM_BUF],
   output logic [BSEL_W-1:0] rd_buf,
   output logic [WIDX_W-1:0] rd_idx,
   input  logic [31:0]       rd_word,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   output logic              tx_last,
   input  logic              tx_ready,
   output logic              done,
   output logic [BSEL_W-1:0] done_buf,
   output logic              mac_we,
   output logic [7:0]        mac_oct [6]
);
   eng_state_e        state;
   logic [BSEL_W-1:0] cur_buf, pick;
   logic [LEN_W-1:0]  cur_len, idx, pick_len;
   logic [31:0]       mac_lo;

   always_comb begin
      pick = '0;
      for (int b = NUM_BUF - 1; b >= 0; b--) begin
         if (start_pend[b]) pick = BSEL_W'(b);
      end
      pick_len = (len_in[pick] > BUS_W'(BUF_BYTES)) ? LEN_W'(BUF_BYTES)
                                                     : len_in[pick][LEN_W-1:0];
   end

   assign tx_valid = (state == ENG_SEND) && (cur_len != '0);
   assign tx_last  = tx_valid && (idx == cur_len - LEN_W'(1));
   assign tx_data  = rd_word[8*idx[1:0] +: 8];
   assign rd_buf   = cur_buf;
   assign done_buf = cur_buf;
   assign rd_idx   = (state == ENG_MAC_LO) ? WIDX_W'(0) :
                     (state == ENG_MAC_HI) ? WIDX_W'(1) : WIDX_W'(idx >> 2);

   always_comb begin
      done = 1'b0;
      unique case (state)
         ENG_SEND:   done = (cur_len == '0) || (tx_ready && tx_last);
         ENG_MAC_HI: done = 1'b1;
         default:    done = 1'b0;
      endcase
   end

   assign mac_we = (state == ENG_MAC_HI);
   for (genvar k = 0; k < 4; k++) begin : g_lo
      assign mac_oct[k] = mac_lo[8*k +: 8];
   end
   for (genvar k = 4; k < 6; k++) begin : g_hi
      assign mac_oct[k] = rd_word[8*(k-4) +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ENG_IDLE;
         cur_buf <= '0;
         cur_len <= '0;
         idx     <= '0;
         mac_lo  <= '0;
      end else begin
         unique case (state)
            ENG_IDLE: if (|start_pend) begin
               cur_buf <= pick;
               cur_len <= pick_len;
               idx     <= '0;
               state   <= prog_pend[pick] ? ENG_MAC_LO : ENG_SEND;
            end
            ENG_SEND: begin
               if (done) state <= ENG_IDLE;
               else if (tx_ready) idx <= idx + LEN_W'(1);
            end
            ENG_MAC_LO: begin
               mac_lo <= rd_word;
               state  <= ENG_MAC_HI;
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/txfb_ctrl.sv
module txfb_ctrl
   import txfb_pkg::*;
#(
   parameter int BUF_BYTES      = 2020,
   parameter bit MAC_FIRST_HIGH = 1'b1,
   localparam int ADDR_W   = 12,
   localparam int NUM_BUF  = 2,
   localparam int WORDS    = BUF_BYTES / 4,
   localparam int LOC_W    = ADDR_W - 3,
   localparam int WIDX_W   = $clog2(WORDS),
   localparam int BSEL_W   = 1,
   localparam logic [LOC_W-1:0] LEN_SLOT  = LOC_W'('h7F4 >> 2),
   localparam logic [LOC_W-1:0] GIE_SLOT  = LOC_W'('h7F8 >> 2),
   localparam logic [LOC_W-1:0] CTRL_SLOT = LOC_W'('h7FC >> 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   output logic              tx_last,
   input  logic              tx_ready,
   output logic [47:0]       mac_addr,
   output logic              irq
);
   if (BUF_BYTES % 4 != 0 || BUF_BYTES > 'h7F4 || BUF_BYTES < 8) begin : g_bad_size
      $error("BUF_BYTES must be a multiple of 4 between 8 and the register block");
   end
   if (WIDX_W > LOC_W) begin : g_bad_idx
      $error("buffer index wider than the local address field");
   end

   logic [BSEL_W-1:0] bsel;
   logic [LOC_W-1:0]  slot;
   logic              is_data;
   assign bsel    = bus_addr[ADDR_W-1];
   assign slot    = bus_addr[ADDR_W-2:2];
   assign is_data = (slot < LOC_W'(WORDS));

   logic [BUS_W-1:0]   len_q  [NUM_BUF];
   logic [BUS_W-1:0]   gie_q  [NUM_BUF];
   logic [BUS_W-1:0]   ctrl_q [NUM_BUF];
   logic [NUM_BUF-1:0] start_bits, prog_bits;

   logic              done, mac_we;
   logic [BSEL_W-1:0] done_buf, eng_buf;
   logic [WIDX_W-1:0] eng_idx;
   logic [31:0]       eng_word, bus_word;
   logic [7:0]        mac_oct [6];

   for (genvar b = 0; b < NUM_BUF; b++) begin : g_regs
      logic hit;
      assign hit = (bsel == BSEL_W'(b));
      txfb_bufregs u_regs (
         .clk    (clk),
         .rst_n  (rst_n),
         .len_we (bus_wr && hit && slot == LEN_SLOT),
         .gie_we (bus_wr && hit && slot == GIE_SLOT),
         .ctrl_we(bus_wr && hit && slot == CTRL_SLOT),
         .wdata  (bus_wdata),
         .done   (done && done_buf == BSEL_W'(b)),
         .len_q  (len_q[b]),
         .gie_q  (gie_q[b]),
         .ctrl_q (ctrl_q[b])
      );
      assign start_bits[b] = ctrl_q[b][CTRL_START];
      assign prog_bits[b]  = ctrl_q[b][CTRL_PROG];
   end

   txfb_bufmem #(.NUM_BUF(NUM_BUF), .WORDS(WORDS)) u_mem (
      .clk    (clk),
      .we     (bus_wr && is_data),
      .wbuf   (bsel),
      .widx   (WIDX_W'(slot)),
      .wdata  (bus_wdata),
      .rbuf_a (eng_buf),
      .ridx_a (eng_idx),
      .rdata_a(eng_word),
      .rbuf_b (bsel),
      .ridx_b (WIDX_W'(slot)),
      .rdata_b(bus_word)
   );

   txfb_engine #(.NUM_BUF(NUM_BUF), .BUF_BYTES(BUF_BYTES)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_pend(start_bits),
      .prog_pend (prog_bits),
      .len_in    (len_q),
      .rd_buf    (eng_buf),
      .rd_idx    (eng_idx),
      .rd_word   (eng_word),
      .tx_data   (tx_data),
      .tx_valid  (tx_valid),
      .tx_last   (tx_last),
      .tx_ready  (tx_ready),
      .done      (done),
      .done_buf  (done_buf),
      .mac_we    (mac_we),
      .mac_oct   (mac_oct)
   );

   logic [47:0] mac_next;
   if (MAC_FIRST_HIGH) begin : g_mac_msb
      assign mac_next = {mac_oct[0], mac_oct[1], mac_oct[2],
                         mac_oct[3], mac_oct[4], mac_oct[5]};
   end else begin : g_mac_lsb
      assign mac_next = {mac_oct[5], mac_oct[4], mac_oct[3],
                         mac_oct[2], mac_oct[1], mac_oct[0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         mac_addr  <= '0;
         irq       <= 1'b0;
      end else begin
         if (bus_rd) begin
            if (is_data)                bus_rdata <= bus_word;
            else if (slot == LEN_SLOT)  bus_rdata <= len_q[bsel];
            else if (slot == GIE_SLOT)  bus_rdata <= gie_q[bsel];
            else if (slot == CTRL_SLOT) bus_rdata <= ctrl_q[bsel];
            else                        bus_rdata <= '0;
         end
         if (mac_we) mac_addr <= mac_next;
         irq <= done && ctrl_q[done_buf][CTRL_IEN] && gie_q[0][GIE_BIT];
      end
   end
endmodule

// File: rtl/txfb_ctrl_chk.sv
module txfb_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        irq,
   input logic        tx_valid,
   input logic        tx_ready,
   input logic        tx_last,
   input logic [7:0]  tx_data,
   input logic [47:0] mac_addr,
   input logic        gie0_en,
   input logic [1:0]  busy
);
   a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(gie0_en));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

   a_r6_stream_busy: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (busy != 2'b00));

   a_r3_last_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   a_r5_mac_on_job: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mac_addr) |-> $past(busy != 2'b00));
endmodule

bind txfb_ctrl txfb_ctrl_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq     (irq),
   .tx_valid(tx_valid),
   .tx_ready(tx_ready),
   .tx_last (tx_last),
   .tx_data (tx_data),
   .mac_addr(mac_addr),
   .gie0_en (gie_q[0][txfb_pkg::GIE_BIT]),
   .busy    (start_bits)
);

// File: tb/sim_txfb_ctrl.sv
`timescale 1ns/1ps
module sim_txfb_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  tx_data;
   logic        tx_valid, tx_last;
   logic        tx_ready = 1'b0;
   logic [47:0] mac_addr;
   logic        irq;

   int n_cmp = 0, n_err = 0, irq_cnt = 0, beat_cnt = 0, ready_mode = 1;
   bit finished = 0;
   logic [8:0] exp_q [$];

   always #4 clk = ~clk;

   txfb_ctrl u0 (.*);

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // ready pattern driver: 0 = held low, 1 = always high, 2 = every other cycle
   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk); #2;
         cyc++;
         tx_ready = (ready_mode == 1) || (ready_mode == 2 && cyc[0]);
      end
   end

   // monitor: pops the scoreboard on each handshake
   always @(negedge clk) begin
      if (rst_n && tx_valid && tx_ready) begin
         beat_cnt++;
         if (exp_q.size() == 0) check("R3 unexpected byte", {tx_last, tx_data}, 9'h1FF);
         else check("R3 byte/last", {tx_last, tx_data}, exp_q.pop_front());
      end
      if (rst_n && irq) irq_cnt++;
   end

   task automatic bwr(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [11:0] a, output logic [31:0] d);
      @(posedge clk); #1;
      bus_rd = 1'b1; bus_addr = a;
      @(posedge clk); #1;
      bus_rd = 1'b0; d = bus_rdata;
   endtask

   function automatic logic [11:0] base(input bit b);
      return b ? 12'h800 : 12'h000;
   endfunction

   // driver: fills the buffer, pushes the expected bytes, writes length
   task automatic load_frame(input bit b, input int len, input logic [7:0] seed, input bit push);
      for (int w = 0; w < (len + 3) / 4; w++) begin
         logic [31:0] d;
         for (int i = 0; i < 4; i++) d[8*i +: 8] = seed + 8'(4*w + i);
         bwr(base(b) + 12'(4*w), d);
      end
      if (push) begin
         for (int i = 0; i < len; i++) exp_q.push_back({(i == len - 1), seed + 8'(i)});
      end
      bwr(base(b) + 12'h7F4, 32'(len));
   endtask

   task automatic wait_idle(input bit b);
      logic [31:0] d;
      for (int i = 0; i < 4000; i++) begin
         brd(base(b) + 12'h7FC, d);
         if (!d[0]) break;
      end
   endtask

   initial begin
      logic [31:0] d;
      int irq0, beat0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      brd(12'h7FC, d); check("R1 ctrl0", d, 0);
      brd(12'hFF4, d); check("R1 len1", d, 0);
      brd(12'h7F8, d); check("R1 gie0", d, 0);
      check("R1 tx_valid", tx_valid, 0);
      check("R1 irq", irq, 0);
      check("R1 mac", mac_addr, 0);

      // R2 address map
      bwr(12'h00C, 32'hCAFE0001);
      bwr(12'h80C, 32'hBEEF0002);
      brd(12'h00C, d); check("R2 buf0 word", d, 32'hCAFE0001);
      brd(12'h80C, d); check("R2 buf1 word", d, 32'hBEEF0002);
      brd(12'h7E4, d); check("R2 unmapped", d, 0);
      bwr(12'hFF8, 32'h1234);
      brd(12'hFF8, d); check("R2 gie1 readback", d, 32'h1234);

      // R3/R4/R6 basic send from buffer 0
      bwr(12'h7F8, 32'h8000_0000);
      irq0 = irq_cnt;
      load_frame(0, 9, 8'h10, 1);
      bwr(12'h7FC, 32'h9);
      wait_idle(0);
      check("R3 frame0 drained", exp_q.size(), 0);
      check("R4 irq after send", irq_cnt - irq0, 1);
      brd(12'h7FC, d); check("R6 ctrl0 after", d, 32'h8);

      // R3/R6/R4 buffer 1 with backpressure, enable from buffer 0
      ready_mode = 2;
      irq0 = irq_cnt;
      load_frame(1, 13, 8'h40, 1);
      bwr(12'hFFC, 32'h109);
      brd(12'hFFC, d); check("R6 ctrl1 busy", d, 32'h109);
      wait_idle(1);
      check("R3 frame1 drained", exp_q.size(), 0);
      check("R4 irq via buffer0 enable", irq_cnt - irq0, 1);
      brd(12'hFFC, d); check("R6 ctrl1 after", d, 32'h108);

      // R7 and R9: stalled send, second start ignored
      ready_mode = 0;
      irq0 = irq_cnt; beat0 = beat_cnt;
      load_frame(0, 4, 8'h70, 1);
      bwr(12'h7FC, 32'h9);
      repeat (4) @(posedge clk);
      #1;
      check("R9 valid held", tx_valid, 1);
      check("R9 first byte held", {tx_last, tx_data}, {1'b0, 8'h70});
      bwr(12'h7FC, 32'h1);
      brd(12'h7FC, d); check("R7 ctrl unchanged", d, 32'h9);
      check("R9 byte still held", {tx_valid, tx_data}, {1'b1, 8'h70});
      ready_mode = 1;
      wait_idle(0);
      check("R7 single frame", beat_cnt - beat0, 4);
      check("R7 enable kept", irq_cnt - irq0, 1);

      // R4 gating: only buffer 0 enable counts
      bwr(12'h7F8, 32'h0);
      bwr(12'hFF8, 32'h8000_0000);
      irq0 = irq_cnt;
      load_frame(0, 3, 8'hA0, 1);
      bwr(12'h7FC, 32'h9);
      wait_idle(0);
      check("R4 no irq when global off", irq_cnt - irq0, 0);
      check("R3 frame sent anyway", exp_q.size(), 0);
      bwr(12'h7F8, 32'h8000_0000);

      // R4 buffer enable bit clear
      irq0 = irq_cnt;
      load_frame(1, 2, 8'hC0, 1);
      bwr(12'hFFC, 32'h1);
      wait_idle(1);
      check("R4 no irq when bit3 clear", irq_cnt - irq0, 0);

      // R5 station address load
      irq0 = irq_cnt; beat0 = beat_cnt;
      bwr(12'h800, 32'h44332211);
      bwr(12'h804, 32'hBBCC6655);
      bwr(12'hFFC, 32'hB);
      wait_idle(1);
      check("R5 mac", mac_addr, 48'h112233445566);
      check("R5 no bytes", beat_cnt - beat0, 0);
      check("R5 irq", irq_cnt - irq0, 1);
      brd(12'hFFC, d); check("R6 ctrl1 after program", d, 32'h8);

      // R8 zero length
      irq0 = irq_cnt; beat0 = beat_cnt;
      bwr(12'h7F4, 32'h0);
      bwr(12'h7FC, 32'h9);
      wait_idle(0);
      check("R8 no bytes", beat_cnt - beat0, 0);
      check("R8 completes with irq", irq_cnt - irq0, 1);

      // R10 write without start
      irq0 = irq_cnt; beat0 = beat_cnt;
      bwr(12'h7F4, 32'h5);
      bwr(12'h7FC, 32'hA);
      repeat (10) @(posedge clk);
      brd(12'h7FC, d); check("R10 job bits zero", d, 32'h8);
      check("R10 no bytes", beat_cnt - beat0, 0);
      check("R10 no irq", irq_cnt - irq0, 0);
      check("R10 mac kept", mac_addr, 48'h112233445566);

      // R3 ping-pong: both buffers queued in turn
      ready_mode = 2;
      load_frame(0, 6, 8'h01, 1);
      load_frame(1, 5, 8'h81, 1);
      bwr(12'h7FC, 32'h1);
      bwr(12'hFFC, 32'h1);
      wait_idle(0);
      wait_idle(1);
      check("R3 ping-pong drained", exp_q.size(), 0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end

   initial begin
      #800000;
      if (!finished) begin
         n_cmp++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
         $finish;
      end
   end
endmodule